// File: doc/BRIEF.md
# T1 Remote Alarm Generator

This block places the remote (yellow) alarm into an outgoing T1 bit stream. It sits beside the transmit framer, which owns the bit, channel and frame counters. Each clock cycle stands for one transmitted bit position. From the current position, the selected framing format and the alarm encoding, the block decides whether the framer must replace that bit. When it must, it also gives the value to send. The framer keeps full control of the framing pattern and of line coding.

Two encodings are available for each framing format, chosen by one select bit. For the 12-frame superframe, the alarm is sent either by clearing bit 2 of every channel or by setting the framing bit of frame 12. For the 24-frame extended superframe, the alarm is sent either as a repeating 16-bit code on the data link or by clearing bit 2 of every channel. The request, the format and the encoding select are all taken only at a superframe start, so an alarm pattern is never cut part way through.

Top module: `ra_yellow_gen`

## Requirements
- R1: After reset, `force_o` stays 0 until a superframe start occurs with `alarm_req_i` high.
- R2: Superframe format (`esf_i`=0) with `alt_fmt_i`=0 and an active alarm: every non-framing bit with `bit_i`==1 (transmitted bit 2 of the channel) and `chan_i` in 0..23 gives `force_o`=1 and `force_val_o`=0. Other bit positions, channel numbers of 24 or more, and all framing bits are not forced.
- R3: Superframe format with `alt_fmt_i`=1 and an active alarm: only the framing bit with `frame_i`==11 (the 12th frame) is forced, and its value is 1.
- R4: Extended superframe (`esf_i`=1) with `alt_fmt_i`=0 and an active alarm: the framing bit of every even `frame_i` (0, 2, ..., 22) is forced to a 16-entry code. The entry index is 0..7 for a 1 and 8..15 for a 0. The index advances by one per data-link slot, wraps from 15 to 0, and continues across superframe starts. Framing bits of odd frames are not forced.
- R5: Extended superframe with `alt_fmt_i`=1 and an active alarm: bit 2 of every channel is forced to 0 as in R2, and no framing bit is forced.
- R6: `alarm_req_i` is sampled only when `frame_i`==0 and `fbit_i`==1 (the superframe start). The sampled value applies from that same bit until the next superframe start.
- R7: `esf_i` and `alt_fmt_i` are sampled only at the superframe start. A change in mid-superframe has no effect until the next start.
- R8: When `force_o` is 0, `force_val_o` is 0.
- R9: A data-link alarm that begins at a superframe start, when it was not sending in the preceding superframe, starts the code at index 0. Its first data-link bit is therefore 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one transmitted bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| esf_i | input | 1 | Framing format: 0 = 12-frame superframe, 1 = 24-frame extended superframe |
| alt_fmt_i | input | 1 | Alarm encoding select: 0 = bit-2 clearing (SF) or data-link code (ESF); 1 = frame-12 framing bit (SF) or bit-2 clearing (ESF) |
| alarm_req_i | input | 1 | Request to send the remote alarm |
| frame_i | input | 5 | Frame number within the superframe, counted from 0 |
| fbit_i | input | 1 | High when the current bit is the framing bit |
| chan_i | input | 5 | Channel number 0..23 for payload bits |
| bit_i | input | 3 | Bit number within the channel, 0 = first bit sent |
| force_o | output | 1 | High when the framer must replace the current bit |
| force_val_o | output | 1 | Value to send when `force_o` is high |

## Verification
Each encoding is driven at the positions where it must act and at the positions next to them. In superframe mode, bit 1 is checked against bit 0, channel 23 against channel 24, and frame 11 against frame 10. These show whether the position decode is off by one. The data-link code is followed over two full extended superframes, so a code that resets at each superframe instead of running on, or that advances on odd frames, reads differently. Changes to the request, the format and the encoding select are made in mid-superframe and again at a start, which separates sampling at the boundary from passing the inputs straight through. The alarm is also stopped and restarted to show whether the code index restarts.

// File: rtl/ra_pkg.sv
package ra_pkg;

  typedef enum logic {
    FMT_SF  = 1'b0,
    FMT_ESF = 1'b1
  } frame_fmt_e;

  typedef struct packed {
    logic       active;
    frame_fmt_e fmt;
    logic       alt;
  } ra_cfg_t;

  localparam ra_cfg_t RA_CFG_IDLE = '{active: 1'b0, fmt: FMT_SF, alt: 1'b0};

endpackage

// File: rtl/ra_slot_dec.sv
module ra_slot_dec #(
  parameter int FRAMES_SF  = 12,
  parameter int FRAMES_ESF = 24,
  parameter int N_CHAN     = 24,
  parameter int N_BITS     = 8,
  parameter int ALARM_BIT  = 1,
  localparam int FW = $clog2(FRAMES_ESF),
  localparam int CW = $clog2(N_CHAN),
  localparam int BW = $clog2(N_BITS)
) (
  input  logic          fbit_i,
  input  logic [FW-1:0] frame_i,
  input  logic [CW-1:0] chan_i,
  input  logic [BW-1:0] bit_i,
  output logic          sf_start_o,
  output logic          dl_slot_o,
  output logic          fs12_slot_o,
  output logic          bit2_slot_o
);

  localparam logic [FW-1:0] LAST_SF_FRAME = FW'(FRAMES_SF - 1);
  localparam logic [FW-1:0] NUM_ESF       = FW'(FRAMES_ESF);
  localparam logic [CW-1:0] NUM_CHAN      = CW'(N_CHAN);
  localparam logic [BW-1:0] TARGET_BIT    = BW'(ALARM_BIT);

  always_comb begin
    sf_start_o  = fbit_i && (frame_i == '0);
    // data link rides on odd frames counted from 1, i.e. even frame_i
    dl_slot_o   = fbit_i && !frame_i[0] && (frame_i < NUM_ESF);
    fs12_slot_o = fbit_i && (frame_i == LAST_SF_FRAME);
    bit2_slot_o = !fbit_i && (bit_i == TARGET_BIT) && (chan_i < NUM_CHAN);
  end

endmodule

// File: rtl/ra_cfg_latch.sv
module ra_cfg_latch
  import ra_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sf_start_i,
  input  logic    alarm_req_i,
  input  logic    esf_i,
  input  logic    alt_fmt_i,
  output ra_cfg_t cfg_o,
  output ra_cfg_t cfg_q_o
);

  ra_cfg_t cfg_q;
  ra_cfg_t cfg_new;

  always_comb begin
    cfg_new.active = alarm_req_i;
    cfg_new.fmt    = esf_i ? FMT_ESF : FMT_SF;
    cfg_new.alt    = alt_fmt_i;
  end

  // new settings apply from the start bit itself
  assign cfg_o   = sf_start_i ? cfg_new : cfg_q;
  assign cfg_q_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RA_CFG_IDLE;
    end else if (sf_start_i) begin
      cfg_q <= cfg_new;
    end
  end

endmodule

// File: rtl/ra_dl_pattern.sv
module ra_dl_pattern #(
  parameter int DL_LEN  = 16,
  parameter int DL_ONES = 8,
  localparam int IW = (DL_LEN > 1) ? $clog2(DL_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  output logic          dl_bit_o,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] cnt_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DL_LEN - 1);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] idx_eff;
  logic [IW-1:0] idx_next;
  logic [DL_LEN-1:0] code;

  genvar g;
  generate
    for (g = 0; g < DL_LEN; g++) begin : g_code
      assign code[g] = (g < DL_ONES);
    end
  endgenerate

  always_comb begin
    idx_eff  = restart_i ? '0 : cnt_q;
    idx_next = (idx_eff == LAST_IDX) ? '0 : idx_eff + 1'b1;
    dl_bit_o = code[idx_eff];
  end

  assign idx_o = idx_eff;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= idx_next;
    end else if (restart_i) begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/ra_yellow_gen.sv
module ra_yellow_gen
  import ra_pkg::*;
#(
  parameter int FRAMES_SF  = 12,
  parameter int FRAMES_ESF = 24,
  parameter int N_CHAN     = 24,
  parameter int N_BITS     = 8,
  parameter int ALARM_BIT  = 1,
  parameter int DL_LEN     = 16,
  localparam int FW = $clog2(FRAMES_ESF),
  localparam int CW = $clog2(N_CHAN),
  localparam int BW = $clog2(N_BITS),
  localparam int IW = (DL_LEN > 1) ? $clog2(DL_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          esf_i,
  input  logic          alt_fmt_i,
  input  logic          alarm_req_i,
  input  logic [FW-1:0] frame_i,
  input  logic          fbit_i,
  input  logic [CW-1:0] chan_i,
  input  logic [BW-1:0] bit_i,
  output logic          force_o,
  output logic          force_val_o
);

  logic    sf_start, dl_slot, fs12_slot, bit2_slot;
  ra_cfg_t cfg, cfg_q;
  logic    dl_on, dl_on_q, dl_restart, dl_step, dl_bit;
  logic    bit2_on, fs12_on;
  logic [IW-1:0] dl_idx, dl_cnt;

  ra_slot_dec #(
    .FRAMES_SF (FRAMES_SF),
    .FRAMES_ESF(FRAMES_ESF),
    .N_CHAN    (N_CHAN),
    .N_BITS    (N_BITS),
    .ALARM_BIT (ALARM_BIT)
  ) u_dec (
    .fbit_i     (fbit_i),
    .frame_i    (frame_i),
    .chan_i     (chan_i),
    .bit_i      (bit_i),
    .sf_start_o (sf_start),
    .dl_slot_o  (dl_slot),
    .fs12_slot_o(fs12_slot),
    .bit2_slot_o(bit2_slot)
  );

  ra_cfg_latch u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sf_start_i (sf_start),
    .alarm_req_i(alarm_req_i),
    .esf_i      (esf_i),
    .alt_fmt_i  (alt_fmt_i),
    .cfg_o      (cfg),
    .cfg_q_o    (cfg_q)
  );

  always_comb begin
    dl_on      = cfg.active && (cfg.fmt == FMT_ESF) && !cfg.alt;
    dl_on_q    = cfg_q.active && (cfg_q.fmt == FMT_ESF) && !cfg_q.alt;
    dl_restart = sf_start && dl_on && !dl_on_q;
    dl_step    = dl_on && dl_slot;
    bit2_on    = cfg.active && ((cfg.fmt == FMT_ESF) ? cfg.alt : !cfg.alt);
    fs12_on    = cfg.active && (cfg.fmt == FMT_SF) && cfg.alt;
  end

  ra_dl_pattern #(
    .DL_LEN (DL_LEN),
    .DL_ONES(DL_LEN / 2)
  ) u_dl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(dl_restart),
    .step_i   (dl_step),
    .dl_bit_o (dl_bit),
    .idx_o    (dl_idx),
    .cnt_o    (dl_cnt)
  );

  always_comb begin
    force_o     = (bit2_on && bit2_slot) || (fs12_on && fs12_slot) || dl_step;
    force_val_o = (fs12_on && fs12_slot) || (dl_step && dl_bit);
  end

endmodule

// File: rtl/ra_yellow_chk.sv
module ra_yellow_chk #(
  parameter int IW = 4,
  parameter int DL_LEN = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fbit_i,
  input logic          sf_start,
  input logic          cfg_active,
  input logic [2:0]    cfg_q_bits,
  input logic          bit2_slot,
  input logic          dl_step,
  input logic          dl_restart,
  input logic          dl_bit,
  input logic [IW-1:0] dl_idx,
  input logic [IW-1:0] dl_cnt,
  input logic          force_o,
  input logic          force_val_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DL_LEN - 1);

  AST_IDLE_NO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_active |-> !force_o) else $error("idle force"); // R1

  AST_PAYLOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_o && !fbit_i) |-> (bit2_slot && !force_val_o)) else $error("payload force"); // R2

  AST_ONE_ON_FBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_val_o |-> fbit_i) else $error("one off framing bit"); // R3

  AST_DL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_step |=> dl_cnt == (($past(dl_idx) == LAST_IDX) ? '0 : $past(dl_idx) + 1'b1))
    else $error("code step"); // R4

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_start |=> $stable(cfg_q_bits)) else $error("cfg changed mid superframe"); // R6

  AST_VAL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_o |-> !force_val_o) else $error("value without force"); // R8

  AST_RESTART_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_restart |-> (dl_idx == '0 && dl_bit)) else $error("restart index"); // R9

endmodule

bind ra_yellow_gen ra_yellow_chk #(
  .IW    (IW),
  .DL_LEN(DL_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fbit_i     (fbit_i),
  .sf_start   (sf_start),
  .cfg_active (cfg.active),
  .cfg_q_bits (cfg_q),
  .bit2_slot  (bit2_slot),
  .dl_step    (dl_step),
  .dl_restart (dl_restart),
  .dl_bit     (dl_bit),
  .dl_idx     (dl_idx),
  .dl_cnt     (dl_cnt),
  .force_o    (force_o),
  .force_val_o(force_val_o)
);

// File: tb/sim_ra_yellow_gen.sv
module sim_ra_yellow_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       esf = 1'b0, alt = 1'b0, req = 1'b0, fbit = 1'b0;
  logic [4:0] frame = '0, chan = '0;
  logic [2:0] bitn = '0;
  logic       force_w, val_w;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ra_yellow_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .esf_i(esf), .alt_fmt_i(alt),
    .alarm_req_i(req), .frame_i(frame), .fbit_i(fbit), .chan_i(chan),
    .bit_i(bitn), .force_o(force_w), .force_val_o(val_w)
  );

  // {rq[3:0], esf, alt, req, frame[4:0], fbit, chan[4:0], bit[2:0], exp_force, exp_val}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {4'd2, 1'b0,1'b0,1'b1, 5'd0, 1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R2 start, fbit untouched
    {4'd2, 1'b0,1'b0,1'b1, 5'd0, 1'b0, 5'd0,  3'd1, 1'b1,1'b0}, // R2
    {4'd2, 1'b0,1'b0,1'b1, 5'd5, 1'b0, 5'd23, 3'd1, 1'b1,1'b0}, // R2
    {4'd8, 1'b0,1'b0,1'b1, 5'd5, 1'b0, 5'd23, 3'd0, 1'b0,1'b0}, // R8
    {4'd2, 1'b0,1'b0,1'b1, 5'd5, 1'b0, 5'd24, 3'd1, 1'b0,1'b0}, // R2 chan 24
    {4'd2, 1'b0,1'b0,1'b1, 5'd11,1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R2
    {4'd6, 1'b0,1'b0,1'b0, 5'd3, 1'b0, 5'd2,  3'd1, 1'b1,1'b0}, // R6 mid drop
    {4'd6, 1'b0,1'b0,1'b0, 5'd0, 1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R6 start off
    {4'd6, 1'b0,1'b0,1'b0, 5'd0, 1'b0, 5'd0,  3'd1, 1'b0,1'b0}, // R6
    {4'd6, 1'b0,1'b1,1'b1, 5'd4, 1'b0, 5'd0,  3'd1, 1'b0,1'b0}, // R6 mid raise
    {4'd3, 1'b0,1'b1,1'b1, 5'd0, 1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R3 start
    {4'd3, 1'b0,1'b1,1'b1, 5'd11,1'b1, 5'd0,  3'd0, 1'b1,1'b1}, // R3
    {4'd3, 1'b0,1'b1,1'b1, 5'd10,1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R3
    {4'd3, 1'b0,1'b1,1'b1, 5'd4, 1'b0, 5'd7,  3'd1, 1'b0,1'b0}, // R3
    {4'd5, 1'b1,1'b1,1'b1, 5'd0, 1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R5 start
    {4'd5, 1'b1,1'b1,1'b1, 5'd7, 1'b0, 5'd12, 3'd1, 1'b1,1'b0}, // R5
    {4'd7, 1'b0,1'b1,1'b1, 5'd11,1'b1, 5'd0,  3'd0, 1'b0,1'b0}, // R7 mid fmt change
    {4'd7, 1'b0,1'b1,1'b1, 5'd5, 1'b0, 5'd3,  3'd1, 1'b1,1'b0}  // R7
  };

  task automatic check(input int rq, input logic ef, input logic ev);
    checks++;
    if (force_w !== ef || val_w !== ev) begin
      errors++;
      $display("FAIL R%0d: force/val = %b/%b, expected %b/%b", rq, force_w, val_w, ef, ev);
    end
  endtask

  task automatic apply(input logic e, input logic a, input logic r, input logic [4:0] fr,
                       input logic fb, input logic [4:0] ch, input logic [2:0] b);
    @(negedge clk);
    esf = e; alt = a; req = r; frame = fr; fbit = fb; chan = ch; bitn = b;
    #1;
  endtask

  task automatic esf_dl_frames(input int nsf, inout int k, input logic r);
    for (int s = 0; s < nsf; s++) begin
      for (int f = 0; f < 24; f++) begin
        apply(1'b1, 1'b0, r, 5'(f), 1'b1, 5'd0, 3'd0);
        if (r && f % 2 == 0) begin
          check(4, 1'b1, (k % 16) < 8); // R4
          k++;
        end else begin
          check(4, 1'b0, 1'b0); // R4 odd frames / idle
        end
      end
    end
  endtask

  initial begin
    int k;
    // R1: reset state
    #2;
    esf = 0; alt = 0; req = 1; frame = 5'd3; fbit = 0; chan = 0; bitn = 3'd1;
    #1 check(1, 1'b0, 1'b0); // R1 in reset
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    apply(1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 5'd0, 3'd1);
    check(1, 1'b0, 1'b0); // R1 no start yet

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      apply(v[18], v[17], v[16], v[15:11], v[10], v[9:5], v[4:2]);
      check(int'(v[22:19]), v[1], v[0]);
    end

    // R4 / R9: data-link code over two superframes, continuing across the start
    k = 0;
    esf_dl_frames(2, k, 1'b1);
    // alarm off for one superframe
    esf_dl_frames(1, k, 1'b0);
    // R9: new episode restarts at index 0
    k = 0;
    apply(1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 5'd0, 3'd0);
    check(9, 1'b1, 1'b1); // R9 first bit is 1
    k = 1;
    for (int f = 2; f <= 18; f += 2) begin
      apply(1'b1, 1'b0, 1'b1, 5'(f), 1'b1, 5'd0, 3'd0);
      check(9, 1'b1, (k % 16) < 8); // R9 sequence after restart
      k++;
    end
    // R4: payload bits not forced in data-link mode
    apply(1'b1, 1'b0, 1'b1, 5'd6, 1'b0, 5'd4, 3'd1);
    check(4, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule